// File: doc/BRIEF.md
# ADC Stuck-Code Repair Filter

This block sits in the sample stream of a multichannel digitizer. The digitizer time-multiplexes several channels onto one 12-bit output. On faulty parts, individual samples sometimes come out with their six low-order bits collapsed to all zeros or all ones, while the high-order bits stay correct. The filter checks every sample for that pattern. It keeps a small history for each channel and rewrites a damaged sample from the clean samples on either side of it on the same channel. Every sample that showed the pattern carries a flag on the output.

Each channel's output runs exactly one sample behind its input. A sample leaves the block when the next sample of the same channel is accepted, and that next sample is the right-hand neighbour used for interpolation. When the right-hand neighbour is damaged too, the last clean sample on the channel is used alone. A repair keeps the damaged sample's six high bits and rewrites only the six low bits, so the corrected value stays inside the coarse bin the converter reported. Each channel has a saturating count of repairs, which can be read through a select input.

Top module: `stuck_code_fixer`

## Requirements
- R1: Synchronous reset clears out_valid, every per-channel repair count and every per-channel history. After reset, the first sample on any channel has no left-hand neighbour.
- R2: A sample is damaged when its six low bits are exactly 0 or exactly 63. The sample is emitted with out_flag=1 when it is damaged and out_flag=0 otherwise. A sample emitted with out_flag=0 never has 0 or 63 in its six low bits.
- R3: A sample on channel c is emitted on out_chan=c, with out_valid high in the cycle after the next channel-c sample is accepted. A clean sample is emitted with its code unchanged, and the samples of one channel keep their order.
- R4: A damaged sample S with last clean sample P and a clean right-hand neighbour N gets the target T = floor((P+N+1)/2). If T[11:6] equals S[11:6], the output is {S[11:6], T[5:0]}. If T[11:6] is greater, the output is {S[11:6], 62}. If T[11:6] is smaller, the output is {S[11:6], 1}.
- R5: When the right-hand neighbour is damaged too, the target is T = P, and the same bit rule as in R4 applies.
- R6: A damaged sample on a channel with no clean sample since reset is emitted unchanged with out_flag=1, and it is not counted.
- R7: Channels are independent. Interleaved samples on other channels do not change a channel's neighbours, its emission point or its count.
- R8: Each repair made under R4 or R5 adds one to that channel's count, and the count saturates at 2^CNT_W-1. cnt_value shows the count of channel cnt_chan one cycle after cnt_chan is applied.
- R9: in_ready is low while out_valid is high and out_ready is low. While out_valid is held in that state, the output does not change.
- R10: Only clean samples become the left-hand neighbour. A repaired sample never replaces the stored clean sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_chan | input | 4 | Channel index of input sample |
| in_code | input | 12 | Raw converter code |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_chan | output | 4 | Channel index of output sample |
| out_code | output | 12 | Emitted, possibly repaired, code |
| out_flag | output | 1 | Sample showed the damage pattern |
| cnt_chan | input | 4 | Channel whose repair count is read |
| cnt_value | output | 4 | Repair count of the selected channel |

## Verification
The repair path is driven with damaged samples whose interpolation target lands in the same coarse bin, above it and below it, which separates the three low-bit choices. One pair of neighbours has an odd sum, so the rounding is tested. Runs of consecutive damaged samples select hold instead of averaging and show that repaired values never become the left-hand neighbour. Samples on several channels are interleaved to show that the histories stay separate. A channel with no history, a long damaged run that saturates the counter, output backpressure and a reset in mid-stream cover the remaining corners.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // How the emitted code of a sample is formed
  typedef enum logic [1:0] {
    FIX_CLEAN = 2'd0,  // sample was clean: passed unchanged
    FIX_RAW   = 2'd1,  // damaged, no left neighbour: passed unchanged
    FIX_AVG   = 2'd2,  // damaged, target is mean of both neighbours
    FIX_HOLD  = 2'd3   // damaged, right neighbour damaged: hold left
  } fix_kind_e;
endpackage

// File: rtl/sc_detect.sv
module sc_detect #(
  parameter int CODE_W = 12,
  parameter int LOW_W  = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic              stuck
);
  logic [LOW_W-1:0] low;
  assign low   = code[LOW_W-1:0];
  assign stuck = (low == '0) || (low == '1);
endmodule

// File: rtl/sc_repair_calc.sv
module sc_repair_calc
  import sc_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LOW_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] s_code,
  input  logic              s_stuck,
  input  logic              p_valid,
  input  logic [CODE_W-1:0] p_code,
  input  logic [CODE_W-1:0] n_code,
  input  logic              n_stuck,
  output logic [CODE_W-1:0] f_code,
  output logic              f_repaired
);
  localparam int HI_W = CODE_W - LOW_W;
  localparam logic [LOW_W-1:0] LOW_NEAR_TOP = {{(LOW_W-1){1'b1}}, 1'b0};
  localparam logic [LOW_W-1:0] LOW_NEAR_BOT = {{(LOW_W-1){1'b0}}, 1'b1};

  fix_kind_e         kind;
  logic [CODE_W:0]   sum;
  logic [CODE_W-1:0] target;
  logic [HI_W-1:0]   t_hi, s_hi;
  logic [LOW_W-1:0]  new_low;

  always_comb begin
    if (!s_stuck)      kind = FIX_CLEAN;
    else if (!p_valid) kind = FIX_RAW;
    else if (n_stuck)  kind = FIX_HOLD;
    else               kind = FIX_AVG;
  end

  assign sum    = {1'b0, p_code} + {1'b0, n_code} + (CODE_W+1)'(1);
  assign target = (kind == FIX_HOLD) ? p_code : sum[CODE_W:1];
  assign t_hi   = target[CODE_W-1:LOW_W];
  assign s_hi   = s_code[CODE_W-1:LOW_W];

  always_comb begin
    if (t_hi == s_hi)     new_low = target[LOW_W-1:0];
    else if (t_hi > s_hi) new_low = LOW_NEAR_TOP;
    else                  new_low = LOW_NEAR_BOT;
  end

  always_comb begin
    f_repaired = (kind == FIX_AVG) || (kind == FIX_HOLD);
    f_code     = f_repaired ? {s_hi, new_low} : s_code;
  end

  // R4: a repair never alters the coarse bits of the damaged sample
  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (en && s_stuck) |-> (f_code[CODE_W-1:LOW_W] == s_code[CODE_W-1:LOW_W]));

  // R6: without a left neighbour the sample leaves untouched
  assert_raw_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !p_valid) |-> (f_code == s_code && !f_repaired));
endmodule

// File: rtl/sc_chan_state.sv
module sc_chan_state #(
  parameter int CH_N   = 16,
  parameter int CODE_W = 12,
  parameter int CNT_W  = 4,
  parameter int CH_W   = $clog2(CH_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   chan,
  output logic              pend_valid,
  output logic [CODE_W-1:0] pend_code,
  output logic              pend_stuck,
  output logic              prev_valid,
  output logic [CODE_W-1:0] prev_code,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_stuck,
  input  logic              upd_prev,
  input  logic              inc_cnt,
  input  logic [CH_W-1:0]   cnt_chan,
  output logic [CNT_W-1:0]  cnt_value
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CODE_W-1:0] pend_code_m [CH_N];
  logic [CODE_W-1:0] prev_code_m [CH_N];
  logic [CH_N-1:0]   pend_stuck_m;
  logic [CH_N-1:0]   pend_valid_m;
  logic [CH_N-1:0]   prev_valid_m;
  logic [CNT_W-1:0]  cnt_m [CH_N];

  assign pend_valid = pend_valid_m[chan];
  assign pend_code  = pend_code_m[chan];
  assign pend_stuck = pend_stuck_m[chan];
  assign prev_valid = prev_valid_m[chan];
  assign prev_code  = prev_code_m[chan];

  // Code storage: no reset, one write port, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      pend_code_m[chan] <= wr_code;
      if (upd_prev) prev_code_m[chan] <= pend_code_m[chan];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid_m <= '0;
      prev_valid_m <= '0;
      pend_stuck_m <= '0;
    end else if (wr_en) begin
      pend_valid_m[chan] <= 1'b1;
      pend_stuck_m[chan] <= wr_stuck;
      if (upd_prev) prev_valid_m[chan] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH_N; i++) cnt_m[i] <= '0;
      cnt_value <= '0;
    end else begin
      if (inc_cnt && cnt_m[chan] != CNT_MAX)
        cnt_m[chan] <= cnt_m[chan] + {{(CNT_W-1){1'b0}}, 1'b1};
      cnt_value <= cnt_m[cnt_chan];
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_chk
    // R8: a full count stays full until reset
    assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (rst)
      (cnt_m[g] == CNT_MAX) |=> (cnt_m[g] == CNT_MAX));
    // R7: counts of channels other than the addressed one are untouched
    assert_cnt_isolated_R7: assert property (@(posedge clk) disable iff (rst)
      (chan != g[CH_W-1:0]) |=> $stable(cnt_m[g]));
  end
endmodule

// File: rtl/stuck_code_fixer.sv
module stuck_code_fixer #(
  parameter int CH_N   = 16,
  parameter int CODE_W = 12,
  parameter int LOW_W  = 6,
  parameter int CNT_W  = 4,
  parameter int CH_W   = $clog2(CH_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [CODE_W-1:0] out_code,
  output logic              out_flag,
  input  logic [CH_W-1:0]   cnt_chan,
  output logic [CNT_W-1:0]  cnt_value
);
  logic              accept, emit;
  logic              in_stuck;
  logic              pv, ps, qv;
  logic [CODE_W-1:0] pc, qc;
  logic [CODE_W-1:0] fix_code;
  logic              fix_rep;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && pv;

  sc_detect #(.CODE_W(CODE_W), .LOW_W(LOW_W)) i_detect (
    .code (in_code),
    .stuck(in_stuck)
  );

  sc_chan_state #(.CH_N(CH_N), .CODE_W(CODE_W), .CNT_W(CNT_W), .CH_W(CH_W)) i_state (
    .clk       (clk),
    .rst       (rst),
    .chan      (in_chan),
    .pend_valid(pv),
    .pend_code (pc),
    .pend_stuck(ps),
    .prev_valid(qv),
    .prev_code (qc),
    .wr_en     (accept),
    .wr_code   (in_code),
    .wr_stuck  (in_stuck),
    .upd_prev  (pv && !ps),
    .inc_cnt   (emit && fix_rep),
    .cnt_chan  (cnt_chan),
    .cnt_value (cnt_value)
  );

  sc_repair_calc #(.CODE_W(CODE_W), .LOW_W(LOW_W)) i_calc (
    .clk       (clk),
    .rst       (rst),
    .en        (emit),
    .s_code    (pc),
    .s_stuck   (ps),
    .p_valid   (qv),
    .p_code    (qc),
    .n_code    (in_code),
    .n_stuck   (in_stuck),
    .f_code    (fix_code),
    .f_repaired(fix_rep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_code  <= '0;
      out_flag  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_chan  <= in_chan;
      out_code  <= fix_code;
      out_flag  <= ps;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled output holds its contents
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_chan) && $stable(out_flag)));

  // R2: an unflagged output never carries the damage pattern
  assert_clean_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_flag) |-> !(out_code[LOW_W-1:0] == '0 || out_code[LOW_W-1:0] == '1));
endmodule

// File: tb/test_stuck_code_fixer.sv
module test_stuck_code_fixer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_chan = '0;
  logic [11:0] in_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_chan;
  logic [11:0] out_code;
  logic        out_flag;
  logic [3:0]  cnt_chan = '0;
  logic [3:0]  cnt_value;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  stuck_code_fixer i_stuck_code_fixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_code(out_code),
    .out_flag(out_flag), .cnt_chan(cnt_chan), .cnt_value(cnt_value)
  );

  // {chan, code, expect_out, exp_chan, exp_code, exp_flag}
  localparam logic [33:0] VEC [0:16] = '{
    {4'd0,  12'h145, 1'b0, 4'd0,  12'h000, 1'b0},
    {4'd0,  12'h1C0, 1'b1, 4'd0,  12'h145, 1'b0}, // R3 clean passes
    {4'd0,  12'h1D0, 1'b1, 4'd0,  12'h1C1, 1'b1}, // R4 target below bin
    {4'd0,  12'h1FF, 1'b1, 4'd0,  12'h1D0, 1'b0},
    {4'd0,  12'h23F, 1'b1, 4'd0,  12'h1D0, 1'b1}, // R5 hold
    {4'd0,  12'h250, 1'b1, 4'd0,  12'h210, 1'b1}, // R10 left stays 0x1D0
    {4'd1,  12'h080, 1'b0, 4'd0,  12'h000, 1'b0},
    {4'd0,  12'h260, 1'b1, 4'd0,  12'h250, 1'b0}, // R7 interleave
    {4'd1,  12'h0A5, 1'b1, 4'd1,  12'h080, 1'b1}, // R6 no history
    {4'd1,  12'h0C0, 1'b1, 4'd1,  12'h0A5, 1'b0},
    {4'd1,  12'h0FA, 1'b1, 4'd1,  12'h0D0, 1'b1}, // R4 same bin
    {4'd2,  12'h2F5, 1'b0, 4'd0,  12'h000, 1'b0},
    {4'd2,  12'h240, 1'b1, 4'd2,  12'h2F5, 1'b0},
    {4'd2,  12'h2EA, 1'b1, 4'd2,  12'h27E, 1'b1}, // R4 above bin, rounding
    {4'd15, 12'hFFF, 1'b0, 4'd0,  12'h000, 1'b0},
    {4'd15, 12'h000, 1'b1, 4'd15, 12'hFFF, 1'b1}, // R2 low=63
    {4'd15, 12'h001, 1'b1, 4'd15, 12'h000, 1'b1}  // R2 low=0
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] ch, input logic [11:0] cd);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_code = cd;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_cnt(input logic [3:0] ch, output logic [3:0] v);
    @(negedge clk);
    cnt_chan = ch;
    @(negedge clk);
    v = cnt_value;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL R9 watchdog: cycles %0d expected below %0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] cv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid after reset", out_valid, 0);
    read_cnt(4'd0, cv);
    check("R1 count after reset", cv, 0);

    for (int i = 0; i < 17; i++) begin
      push(VEC[i][33:30], VEC[i][29:18]);
      if (VEC[i][17]) begin
        check($sformatf("R3 vec %0d valid", i), out_valid, 1);
        check($sformatf("R7 vec %0d chan", i), out_chan, VEC[i][16:13]);
        check($sformatf("R4 vec %0d code", i), out_code, VEC[i][12:1]);
        check($sformatf("R2 vec %0d flag", i), out_flag, VEC[i][0]);
      end else begin
        check($sformatf("R3 vec %0d no output", i), out_valid, 0);
      end
    end

    read_cnt(4'd0, cv);  check("R8 count ch0", cv, 3);
    read_cnt(4'd1, cv);  check("R6 count ch1", cv, 1);
    read_cnt(4'd2, cv);  check("R8 count ch2", cv, 1);
    read_cnt(4'd15, cv); check("R6 count ch15", cv, 0);

    // R8 saturation: 20 damaged samples after one clean one on channel 3
    push(4'd3, 12'h105);
    for (int k = 0; k < 20; k++) push(4'd3, 12'h100);
    check("R5 hold code", out_code, 12'h105);
    check("R5 hold flag", out_flag, 1);
    read_cnt(4'd3, cv);
    check("R8 saturated count", cv, 15);

    // R9 backpressure on channel 4
    out_ready = 1'b0;
    push(4'd4, 12'h105);
    push(4'd4, 12'h120);
    check("R9 out_valid stalled", out_valid, 1);
    check("R9 in_ready low", in_ready, 0);
    in_valid = 1'b1; in_chan = 4'd4; in_code = 12'h130;
    repeat (3) @(negedge clk);
    check("R9 code held", out_code, 12'h105);
    check("R9 in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 next in order", out_code, 12'h120);
    check("R3 valid after release", out_valid, 1);

    // R1 mid-stream reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 out_valid cleared", out_valid, 0);
    read_cnt(4'd0, cv);
    check("R1 count cleared", cv, 0);
    push(4'd0, 12'h1C0);
    check("R1 history cleared", out_valid, 0);
    push(4'd0, 12'h1D0);
    check("R1 raw after reset code", out_code, 12'h1C0);
    check("R6 raw after reset flag", out_flag, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule